// File: doc/BRIEF.md
# Conservative Load-Store Queue Scheduler

This block is a small circular queue that sits after register renaming and holds only memory micro-ops, apart from the general issue queue. Each entry carries a physical tag for its base register, a signed immediate and, for a store, a physical tag for the data to be written. The entries are filled in program order. Every cycle each entry compares its outstanding tags against a single register-ready broadcast and captures the value when the tag matches.

An operation passes through two steps. Once its base value is held, a single shared adder forms the effective address. After that, the operation competes for the one memory request port. The disambiguation rules are conservative. A load waits while any store older than it still lacks an address. A load may pass older stores whose addresses are known. A store waits until it is the oldest entry and its data is held. When memory answers with the entry's index, that entry is marked complete, and the oldest end of the queue then moves past every adjacent completed entry.

Top module: `lsq_sched`

## Requirements
- R1: While `rst` is high at a clock edge the queue becomes empty. After reset `alloc_ready` is 1, `mem_req_valid` is 0, and the first allocated entry gets slot index 0.
- R2: An entry is written when `alloc_valid` and `alloc_ready` are both 1 at a clock edge. The k-th entry of program order, counted from the oldest, sits in slot (oldest slot + k) mod DEPTH. `alloc_ready` is 0 exactly when DEPTH entries are held, and an offer made then is dropped.
- R3: An entry waiting on a tag captures `wb_value` when `wb_valid` is 1 and `wb_tag` equals that tag, including in its own allocation cycle. Base and store-data tags are handled alike. A value once captured is never overwritten by a later broadcast.
- R4: At most one entry gets an address per cycle: the oldest that holds its base value and has no address yet. The address is the base value plus the immediate sign-extended from bit IMM_W-1, modulo 2^VAL_W. It is usable for a request from the next cycle on.
- R5: A load with an address never requests while any older entry in the queue is a store without an address.
- R6: A load may request ahead of older stores that have addresses, even when those stores have not yet issued.
- R7: A store requests only when it is the oldest entry in the queue and its data value is held.
- R8: Each cycle `mem_req_valid` shows the oldest eligible entry, with `mem_req_idx` its slot, `mem_req_store` 1 for a store and 0 for a load, `mem_req_addr` its address, and `mem_req_data` the store data (0 for a load). The request is taken, and the entry never requests again, on an edge where `mem_req_ready` is 1.
- R9: A `mem_resp_valid` naming an issued slot marks it complete. At the following edge the oldest end advances past all adjacent completed entries at once, freeing their slots for allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New memory op offered in program order |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_base_tag | input | TAG_W | Physical tag of the base register |
| alloc_imm | input | IMM_W | Signed address offset |
| alloc_data_tag | input | TAG_W | Physical tag of store data (ignored for loads) |
| wb_valid | input | 1 | Register-ready broadcast present |
| wb_tag | input | TAG_W | Tag being broadcast |
| wb_value | input | VAL_W | Value of the broadcast register |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_idx | output | $clog2(DEPTH) | Slot of the requesting entry |
| mem_req_store | output | 1 | Request is a store |
| mem_req_addr | output | VAL_W | Effective address |
| mem_req_data | output | VAL_W | Store data, 0 for loads |
| mem_resp_valid | input | 1 | Completion for one slot |
| mem_resp_idx | input | $clog2(DEPTH) | Slot being completed |

## Verification
The assertions assume that memory answers only slots it has accepted and not yet answered, each exactly once, and that no response arrives during the cycle of acceptance. The bench's responder draws only from its own list of accepted slots and schedules each answer one or more cycles after acceptance. The bench also assumes that every tag an entry waits on is broadcast eventually. Its stimulus therefore usually broadcasts a tag that some live entry awaits, and it sometimes broadcasts the tag being allocated in the same cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   // per-entry control flags
   typedef struct packed {
      logic vld;    // slot holds a live op
      logic st;     // op is a store
      logic brdy;   // base value captured
      logic drdy;   // store data captured (forced for loads)
      logic aok;    // effective address formed
      logic iss;    // request accepted by memory
      logic dn;     // memory completed the op
   } lsq_flags_t;

   // distance of a slot from the oldest slot in a ring of the given size
   function automatic int unsigned ring_age(int unsigned slot, int unsigned base,
                                            int unsigned depth);
      return (slot + depth - base) % depth;
   endfunction

endpackage

// File: rtl/lsq_age_pick.sv
// Picks the first requesting slot walking forward from base (oldest first).
module lsq_age_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         req,
   input  logic [$clog2(N)-1:0] base,
   output logic                 hit,
   output logic [$clog2(N)-1:0] sel
);
   localparam int IW = $clog2(N);

   always_comb begin
      hit = 1'b0;
      sel = base;
      for (int k = 0; k < N; k++) begin
         if (!hit && req[base + IW'(k)]) begin
            hit = 1'b1;
            sel = base + IW'(k);
         end
      end
   end
endmodule

// File: rtl/lsq_hazard.sv
// Issue eligibility per slot under conservative memory disambiguation.
module lsq_hazard
   import lsq_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [$clog2(N)-1:0] head,
   input  logic [N-1:0]         vld,
   input  logic [N-1:0]         st,
   input  logic [N-1:0]         aok,
   input  logic [N-1:0]         iss,
   input  logic [N-1:0]         dn,
   input  logic [N-1:0]         drdy,
   output logic [N-1:0]         elig
);
   localparam int IW = $clog2(N);

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic older_blind;   // an older store still lacks its address
      always_comb begin
         older_blind = 1'b0;
         for (int j = 0; j < N; j++) begin
            if (vld[j] && st[j] && !aok[j] &&
                ring_age(j, int'(head), N) < ring_age(i, int'(head), N))
               older_blind = 1'b1;
         end
      end
      assign elig[i] = vld[i] && aok[i] && !iss[i] && !dn[i] &&
                       (st[i] ? (IW'(i) == head && drdy[i]) : !older_blind);
   end
endmodule

// File: rtl/lsq_sched.sv
module lsq_sched
   import lsq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TAG_W = 6,
   parameter int VAL_W = 16,
   parameter int IMM_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     alloc_valid,
   output logic                     alloc_ready,
   input  logic                     alloc_is_store,
   input  logic [TAG_W-1:0]         alloc_base_tag,
   input  logic [IMM_W-1:0]         alloc_imm,
   input  logic [TAG_W-1:0]         alloc_data_tag,
   input  logic                     wb_valid,
   input  logic [TAG_W-1:0]         wb_tag,
   input  logic [VAL_W-1:0]         wb_value,
   output logic                     mem_req_valid,
   input  logic                     mem_req_ready,
   output logic [$clog2(DEPTH)-1:0] mem_req_idx,
   output logic                     mem_req_store,
   output logic [VAL_W-1:0]         mem_req_addr,
   output logic [VAL_W-1:0]         mem_req_data,
   input  logic                     mem_resp_valid,
   input  logic [$clog2(DEPTH)-1:0] mem_resp_idx
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lsq_sched: DEPTH must be a power of two of at least 2");
   end
   if (TAG_W < 1 || VAL_W < 1 || IMM_W < 1 || IMM_W > VAL_W) begin : g_bad_width
      $error("lsq_sched: widths must be positive and IMM_W <= VAL_W");
   end

   // storage
   lsq_flags_t       flg     [DEPTH];
   logic [TAG_W-1:0] btag_q  [DEPTH];
   logic [TAG_W-1:0] dtag_q  [DEPTH];
   logic [IMM_W-1:0] imm_q   [DEPTH];
   logic [VAL_W-1:0] bval_q  [DEPTH];
   logic [VAL_W-1:0] dval_q  [DEPTH];
   logic [VAL_W-1:0] addr_q  [DEPTH];

   logic [PW-1:0] head, tail, occ, pop_n;
   logic [IW-1:0] head_i, tail_i, scan;
   logic          full, alloc_fire, stop;
   logic [DEPTH-1:0] vld_v, st_v, brdy_v, drdy_v, aok_v, iss_v, dn_v, pop_mask;

   assign head_i     = head[IW-1:0];
   assign tail_i     = tail[IW-1:0];
   assign occ        = tail - head;
   assign full       = (occ == PW'(DEPTH));
   assign alloc_ready = !full;
   assign alloc_fire = alloc_valid && !full;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         vld_v[i]  = flg[i].vld;
         st_v[i]   = flg[i].st;
         brdy_v[i] = flg[i].brdy;
         drdy_v[i] = flg[i].drdy;
         aok_v[i]  = flg[i].aok;
         iss_v[i]  = flg[i].iss;
         dn_v[i]   = flg[i].dn;
      end
   end

   // retire: walk from the oldest slot over adjacent completed entries
   always_comb begin
      stop     = 1'b0;
      pop_n    = '0;
      pop_mask = '0;
      scan     = head_i;
      for (int k = 0; k < DEPTH; k++) begin
         scan = head_i + IW'(k);
         if (!stop && vld_v[scan] && dn_v[scan]) begin
            pop_mask[scan] = 1'b1;
            pop_n          = pop_n + PW'(1);
         end else begin
            stop = 1'b1;
         end
      end
   end

   // address generation: one shared adder for the oldest waiting entry
   logic             agen_hit;
   logic [IW-1:0]    agen_sel;
   logic [VAL_W-1:0] imm_ext, agen_sum;
   logic [IMM_W-1:0] agen_imm;

   lsq_age_pick #(.N(DEPTH)) u_agen_pick (
      .req  (vld_v & brdy_v & ~aok_v),
      .base (head_i),
      .hit  (agen_hit),
      .sel  (agen_sel)
   );

   assign agen_imm = imm_q[agen_sel];
   if (IMM_W == VAL_W) begin : g_imm_full
      assign imm_ext = agen_imm;
   end else begin : g_imm_sext
      assign imm_ext = {{(VAL_W - IMM_W){agen_imm[IMM_W-1]}}, agen_imm};
   end
   assign agen_sum = bval_q[agen_sel] + imm_ext;

   // issue selection
   logic [DEPTH-1:0] elig;
   logic             issue_hit, issue_fire;
   logic [IW-1:0]    issue_sel;

   lsq_hazard #(.N(DEPTH)) u_hazard (
      .head (head_i),
      .vld  (vld_v),
      .st   (st_v),
      .aok  (aok_v),
      .iss  (iss_v),
      .dn   (dn_v),
      .drdy (drdy_v),
      .elig (elig)
   );

   lsq_age_pick #(.N(DEPTH)) u_issue_pick (
      .req  (elig),
      .base (head_i),
      .hit  (issue_hit),
      .sel  (issue_sel)
   );

   assign issue_fire    = issue_hit && mem_req_ready;
   assign mem_req_valid = issue_hit;
   assign mem_req_idx   = issue_sel;
   assign mem_req_store = st_v[issue_sel];
   assign mem_req_addr  = addr_q[issue_sel];
   assign mem_req_data  = st_v[issue_sel] ? dval_q[issue_sel] : '0;

   // state update
   always_ff @(posedge clk) begin
      if (rst) begin
         head <= '0;
         tail <= '0;
         for (int i = 0; i < DEPTH; i++) flg[i] <= '0;
      end else begin
         head <= head + pop_n;
         tail <= tail + PW'(alloc_fire);
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && tail_i == IW'(i)) begin
               flg[i].vld  <= 1'b1;
               flg[i].st   <= alloc_is_store;
               flg[i].brdy <= wb_valid && wb_tag == alloc_base_tag;
               flg[i].drdy <= !alloc_is_store || (wb_valid && wb_tag == alloc_data_tag);
               flg[i].aok  <= 1'b0;
               flg[i].iss  <= 1'b0;
               flg[i].dn   <= 1'b0;
               btag_q[i]   <= alloc_base_tag;
               dtag_q[i]   <= alloc_data_tag;
               imm_q[i]    <= alloc_imm;
               bval_q[i]   <= wb_value;
               dval_q[i]   <= wb_value;
            end else if (flg[i].vld) begin
               if (pop_mask[i]) flg[i].vld <= 1'b0;
               if (!flg[i].brdy && wb_valid && wb_tag == btag_q[i]) begin
                  flg[i].brdy <= 1'b1;
                  bval_q[i]   <= wb_value;
               end
               if (!flg[i].drdy && wb_valid && wb_tag == dtag_q[i]) begin
                  flg[i].drdy <= 1'b1;
                  dval_q[i]   <= wb_value;
               end
               if (agen_hit && agen_sel == IW'(i)) begin
                  flg[i].aok <= 1'b1;
                  addr_q[i]  <= agen_sum;
               end
               if (issue_fire && issue_sel == IW'(i)) flg[i].iss <= 1'b1;
               if (mem_resp_valid && mem_resp_idx == IW'(i) && flg[i].iss)
                  flg[i].dn <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lsq_sched_chk.sv
module lsq_sched_chk
   import lsq_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic [$clog2(DEPTH):0]   occ,
   input logic [$clog2(DEPTH)-1:0] head_i,
   input logic [DEPTH-1:0]         vld_v,
   input logic [DEPTH-1:0]         st_v,
   input logic [DEPTH-1:0]         aok_v,
   input logic [DEPTH-1:0]         iss_v,
   input logic [DEPTH-1:0]         dn_v,
   input logic                     alloc_ready,
   input logic                     mem_req_valid,
   input logic [$clog2(DEPTH)-1:0] mem_req_idx,
   input logic                     mem_req_store,
   input logic                     mem_resp_valid,
   input logic [$clog2(DEPTH)-1:0] mem_resp_idx
);
   logic blind_store_ahead;
   always_comb begin
      blind_store_ahead = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
         if (vld_v[j] && st_v[j] && !aok_v[j] &&
             ring_age(j, int'(head_i), DEPTH) < ring_age(int'(mem_req_idx), int'(head_i), DEPTH))
            blind_store_ahead = 1'b1;
      end
   end

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
      int'(occ) <= DEPTH); // R2
   AST_FULL_ALL_LIVE: assert property (@(posedge clk) disable iff (rst)
      !alloc_ready |-> (&vld_v)); // R2
   AST_ONE_AGEN: assert property (@(posedge clk) disable iff (rst)
      $countones(aok_v & ~$past(aok_v)) <= 1); // R4
   AST_REQ_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> (vld_v[mem_req_idx] && aok_v[mem_req_idx] && !iss_v[mem_req_idx])); // R4
   AST_LOAD_NO_BLIND_PASS: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_store) |-> !blind_store_ahead); // R5
   AST_STORE_OLDEST: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && mem_req_store) |-> (mem_req_idx == head_i)); // R7
   AST_RESP_MARKS_DONE: assert property (@(posedge clk) disable iff (rst)
      mem_resp_valid |=> dn_v[$past(mem_resp_idx)]); // R9
endmodule

bind lsq_sched lsq_sched_chk #(.DEPTH(DEPTH)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .occ            (occ),
   .head_i         (head_i),
   .vld_v          (vld_v),
   .st_v           (st_v),
   .aok_v          (aok_v),
   .iss_v          (iss_v),
   .dn_v           (dn_v),
   .alloc_ready    (alloc_ready),
   .mem_req_valid  (mem_req_valid),
   .mem_req_idx    (mem_req_idx),
   .mem_req_store  (mem_req_store),
   .mem_resp_valid (mem_resp_valid),
   .mem_resp_idx   (mem_resp_idx)
);

// File: tb/sim_lsq_sched.sv
module sim_lsq_sched;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int TAG_W = 6;
   localparam int VAL_W = 16;
   localparam int IMM_W = 12;
   localparam int IW = $clog2(DEPTH);

   logic clk, rst;
   logic alloc_valid, alloc_ready, alloc_is_store;
   logic [TAG_W-1:0] alloc_base_tag, alloc_data_tag, wb_tag;
   logic [IMM_W-1:0] alloc_imm;
   logic wb_valid;
   logic [VAL_W-1:0] wb_value, mem_req_addr, mem_req_data;
   logic mem_req_valid, mem_req_ready, mem_req_store, mem_resp_valid;
   logic [IW-1:0] mem_req_idx, mem_resp_idx;

   lsq_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .VAL_W(VAL_W), .IMM_W(IMM_W)) u0 (
      .clk(clk), .rst(rst),
      .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_is_store(alloc_is_store), .alloc_base_tag(alloc_base_tag),
      .alloc_imm(alloc_imm), .alloc_data_tag(alloc_data_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_idx(mem_req_idx), .mem_req_store(mem_req_store),
      .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
      .mem_resp_valid(mem_resp_valid), .mem_resp_idx(mem_resp_idx)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0, failures = 0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // behavioural reference: program-ordered list of live ops
   typedef struct {
      bit st; int btag; int dtag; bit brdy; bit drdy;
      logic [VAL_W-1:0] bval; logic [VAL_W-1:0] dval;
      int imm; bit aok; logic [VAL_W-1:0] addr; bit iss; bit dn; int slot;
   } op_t;
   op_t ops[$];
   int  oldest_slot = 0;
   int  pend_slot[$];
   int  pend_due[$];
   int  cyc_no = 0;
   int  lat_max = 0;
   bit  e_val;
   int  e_k;
   int  n_full = 0, n_bypass = 0, n_multipop = 0, n_same = 0;

   function automatic int sext_imm(logic [IMM_W-1:0] r);
      if (r[IMM_W-1]) return int'(r) - (1 << IMM_W);
      return int'(r);
   endfunction

   function automatic void model_eval();
      e_val = 0;
      e_k = -1;
      for (int k = 0; k < ops.size(); k++) begin
         bit ok;
         ok = ops[k].aok && !ops[k].iss && !ops[k].dn;
         if (ops[k].st) ok = ok && k == 0 && ops[k].drdy;
         else
            for (int j = 0; j < k; j++)
               if (ops[j].st && !ops[j].aok) ok = 0;
         if (ok && !e_val) begin
            e_val = 1;
            e_k = k;
         end
      end
   endfunction

   task automatic compare_outputs();
      model_eval();
      chk(alloc_ready === (ops.size() < DEPTH), "R2 alloc_ready", alloc_ready, ops.size() < DEPTH);
      chk(mem_req_valid === e_val, "R5/R6/R7 mem_req_valid", mem_req_valid, e_val);
      if (e_val && mem_req_valid) begin
         chk(int'(mem_req_idx) == ops[e_k].slot, "R8 oldest eligible slot", mem_req_idx, ops[e_k].slot);
         chk(mem_req_store == ops[e_k].st, "R7 request kind", mem_req_store, ops[e_k].st);
         chk(mem_req_addr == ops[e_k].addr, "R4 effective address", mem_req_addr, ops[e_k].addr);
         chk(mem_req_data == (ops[e_k].st ? ops[e_k].dval : '0), "R8 request data",
             mem_req_data, ops[e_k].st ? ops[e_k].dval : '0);
      end
   endtask

   // one clock: drive at negedge, update model, compare at the next negedge
   task automatic cyc(input bit av, input bit ast, input int abt, input logic [IMM_W-1:0] aim,
                      input int adt, input bit wv, input int wt, input logic [VAL_W-1:0] wval,
                      input bit rdy);
      bit rv = 0;
      int ri = 0;
      int size_pre, npop;
      for (int p = 0; p < pend_slot.size(); p++) begin
         if (pend_due[p] <= cyc_no) begin
            rv = 1;
            ri = pend_slot[p];
            pend_slot.delete(p);
            pend_due.delete(p);
            break;
         end
      end
      alloc_valid = av; alloc_is_store = ast;
      alloc_base_tag = TAG_W'(abt); alloc_data_tag = TAG_W'(adt); alloc_imm = aim;
      wb_valid = wv; wb_tag = TAG_W'(wt); wb_value = wval;
      mem_req_ready = rdy; mem_resp_valid = rv; mem_resp_idx = IW'(ri);

      model_eval();
      size_pre = ops.size();
      npop = 0;
      while (npop < ops.size() && ops[npop].dn) npop++;
      if (npop >= 2) n_multipop++;
      if (e_val && rdy) begin
         for (int j = 0; j < e_k; j++)
            if (ops[j].st && !ops[j].iss && !ops[e_k].st) begin
               n_bypass++;
               break;
            end
         ops[e_k].iss = 1;
         pend_slot.push_back(ops[e_k].slot);
         pend_due.push_back(cyc_no + 1 + (lat_max > 0 ? int'($urandom % lat_max) : 0));
      end
      for (int k = 0; k < ops.size(); k++)
         if (ops[k].brdy && !ops[k].aok) begin
            ops[k].aok = 1;
            ops[k].addr = ops[k].bval + ops[k].imm[VAL_W-1:0];
            break;
         end
      if (wv)
         for (int k = 0; k < ops.size(); k++) begin
            if (!ops[k].brdy && ops[k].btag == wt) begin ops[k].brdy = 1; ops[k].bval = wval; end
            if (!ops[k].drdy && ops[k].dtag == wt) begin ops[k].drdy = 1; ops[k].dval = wval; end
         end
      if (rv)
         for (int k = 0; k < ops.size(); k++)
            if (ops[k].slot == ri && ops[k].iss && !ops[k].dn) ops[k].dn = 1;
      if (av) begin
         if (size_pre >= DEPTH) n_full++;
         else begin
            op_t m;
            m.st = ast; m.btag = abt; m.dtag = adt;
            m.brdy = wv && wt == abt; m.bval = wval;
            m.drdy = !ast || (wv && wt == adt); m.dval = wval;
            m.imm = sext_imm(aim); m.aok = 0; m.addr = '0; m.iss = 0; m.dn = 0;
            m.slot = (oldest_slot + size_pre) % DEPTH;
            if (m.brdy) n_same++;
            ops.push_back(m);
         end
      end
      repeat (npop) void'(ops.pop_front());
      oldest_slot = (oldest_slot + npop) % DEPTH;

      @(posedge clk);
      @(negedge clk);
      cyc_no++;
      compare_outputs();
   endtask

   task automatic idle(input bit rdy);
      cyc(0, 0, 0, '0, 0, 0, 0, '0, rdy);
   endtask

   task automatic rand_cycle(input bit allow_alloc);
      bit av, ast, wv, rdy;
      int abt, adt, wt;
      av  = allow_alloc && ($urandom % 100) < 55;
      ast = ($urandom % 100) < 40;
      abt = int'($urandom % 16);
      adt = int'($urandom % 16);
      wv = 0; wt = 0;
      if (ops.size() > 0 && ($urandom % 100) < 60) begin
         int k;
         k = int'($urandom % ops.size());
         if (!ops[k].brdy) begin wv = 1; wt = ops[k].btag; end
         else if (!ops[k].drdy) begin wv = 1; wt = ops[k].dtag; end
      end
      if (!wv && av && ($urandom % 100) < 25) begin wv = 1; wt = abt; end
      rdy = ($urandom % 100) < 70;
      cyc(av, ast, abt, IMM_W'($urandom), adt, wv, wt, VAL_W'($urandom), rdy);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", cyc_no, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1;
      alloc_valid = 0; alloc_is_store = 0; alloc_base_tag = '0; alloc_imm = '0;
      alloc_data_tag = '0; wb_valid = 0; wb_tag = '0; wb_value = '0;
      mem_req_ready = 0; mem_resp_valid = 0; mem_resp_idx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R1: empty after reset
      chk(alloc_ready === 1'b1, "R1 alloc_ready after reset", alloc_ready, 1);
      chk(mem_req_valid === 1'b0, "R1 no request after reset", mem_req_valid, 0);

      // directed: store (base tag 1, data tag 3) then load (base tag 2, imm -4)
      lat_max = 0;
      cyc(1, 1, 1, 12'h000, 3, 0, 0, '0, 0);
      cyc(1, 0, 2, 12'hFFC, 0, 1, 2, 16'd100, 0);   // R3 capture in allocation cycle
      idle(0);
      chk(mem_req_valid === 1'b0, "R5 load held behind store without address", mem_req_valid, 0);
      cyc(0, 0, 0, '0, 0, 1, 1, 16'd200, 0);
      chk(mem_req_valid === 1'b0, "R5 store address not yet formed", mem_req_valid, 0);
      idle(0);
      chk(mem_req_valid === 1'b1 && mem_req_idx == 1 && !mem_req_store,
          "R6 load passes store with known address", {mem_req_valid, mem_req_idx}, {1'b1, 3'd1});
      chk(mem_req_addr == 16'h0060, "R4 base plus negative offset", mem_req_addr, 16'h0060);
      cyc(0, 0, 0, '0, 0, 1, 2, 16'hBEEF, 1);       // R3 late broadcast must not overwrite
      chk(mem_req_valid === 1'b0, "R7 store waits for its data", mem_req_valid, 0);
      cyc(0, 0, 0, '0, 0, 1, 3, 16'h0055, 0);
      chk(mem_req_valid === 1'b1 && mem_req_store && mem_req_idx == 0,
          "R7 oldest store with data issues", {mem_req_valid, mem_req_store, mem_req_idx}, {2'b11, 3'd0});
      chk(mem_req_addr == 16'd200 && mem_req_data == 16'h0055, "R8 store address and data",
          {mem_req_addr, mem_req_data}, {16'd200, 16'h0055});
      repeat (4) idle(1);
      chk(alloc_ready === 1'b1 && ops.size() == 0, "R9 queue drained after responses", alloc_ready, 1);

      // random traffic with out-of-order response latency
      lat_max = 5;
      for (int n = 0; n < 3000; n++) rand_cycle(1);
      for (int n = 0; n < 3000 && (ops.size() > 0 || pend_slot.size() > 0); n++) rand_cycle(0);

      chk(ops.size() == 0 && alloc_ready === 1'b1, "R9 all entries retired", ops.size(), 0);
      chk(n_full > 0, "R2 full-queue stall exercised", n_full, 1);
      chk(n_bypass > 0, "R6 load bypass exercised", n_bypass, 1);
      chk(n_multipop > 0, "R9 multi-entry retire exercised", n_multipop, 1);
      chk(n_same > 0, "R3 same-cycle capture exercised", n_same, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule